// File: doc/BRIEF.md
# Inter-Subarray Row Copy Sequencer

This block sits in a memory controller, one instance per bank. It takes a request to copy one row of a subarray into one or more other subarrays of the same bank. It turns that request into a timed stream of DRAM commands.

Each subarray carries two extra "shared" rows. Each shared row can be opened onto a bank-wide bus through its own global wordline. The bus path bypasses the local sense amplifiers.

When the data is not yet staged, the sequencer first clones the source row into a shared row of the same subarray. It does this with two local activations and a local precharge. It then opens the source shared row onto the bus and, a short fixed gap later, opens the shared rows of every destination at once. After the row-active time it closes the bus with a bus precharge and, once the precharge time has elapsed, reports completion.

The two shared rows of each subarray are used alternately, so one of them can hold a result while the other receives new data. A single-entry holding register with a valid/ready handshake accepts the next request while a transfer is in progress. The sequencer rejects requests with a malformed destination set. All DRAM timings are parameters counted in controller cycles.

Top module: `xsub_copy_seq`

## Requirements
- R1: For a request that is not staged, the first three commands are ACT_ROW (op 1, row field = source row), then ACT_SHR (op 2, row field = shared slot being written) T_RCD cycles later, then PRE_SUB (op 3) T_RAS cycles after that. Each of these names the source subarray.
- R2: The bus phase consists of GWL_SRC (op 4, row field = source slot being read), then GWL_DST (op 5) exactly T_GAP cycles later, then PRE_BUS (op 6) T_RAS cycles after GWL_DST. For a cloned request, GWL_SRC follows PRE_SUB by T_RP cycles. GWL_DST carries the destination mask in cmd_mask and the slot written in each destination in cmd_slots. Every other command has cmd_mask and cmd_slots at zero, and all commands carry the source subarray in cmd_sub.
- R3: A staged request issues no ops 1 to 3. GWL_SRC is its first command, issued in the cycle after the request leaves the holding register, and it reads the slot most recently written in the source subarray.
- R4: A request whose destination mask has more than MAX_DST (default 4) bits set is rejected: err pulses and no command is issued for it.
- R5: A request with an empty destination mask, or with the source subarray's own bit set in the mask, is rejected. err pulses for one cycle in the cycle the request leaves the holding register, and no command is issued for it.
- R6: Each subarray has a one-bit write slot that is 0 after reset. A clone into a source subarray, or a bus write into a destination subarray, uses the current write slot and then flips it. A bus read uses the inverse of the source's write slot, which is the slot written last.
- R7: sub_busy has the source subarray's bit set from the ACT_ROW cycle through the cycle before GWL_SRC. It is zero for staged requests and throughout every bus phase.
- R8: req_ready is high exactly when the holding register is empty. A held request is taken in a cycle where the engine is idle, and at most one transfer is in progress at a time.
- R9: done pulses for one cycle T_RP cycles after PRE_BUS. Each done_slots bit of a destination gives the slot written there; all other bits are zero. busy is high from the first command through the done cycle.
- R10: After reset, req_ready is 1 and busy, cmd_valid, done, err and sub_busy are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Copy request present |
| req_ready | output | 1 | Holding register empty |
| req_src | input | SUB_W | Source subarray index |
| req_row | input | ROW_W | Source row within the subarray |
| req_mask | input | NUM_SUB | Destination subarray mask |
| req_staged | input | 1 | Data already sits in a shared row of the source |
| cmd_valid | output | 1 | Command strobe, one cycle |
| cmd_op | output | 3 | Opcode 1..6 (see R1, R2) |
| cmd_sub | output | SUB_W | Source subarray of the command |
| cmd_row | output | ROW_W | Row address or shared-slot index |
| cmd_mask | output | NUM_SUB | Destination mask for GWL_DST |
| cmd_slots | output | NUM_SUB | Destination slot per subarray for GWL_DST |
| busy | output | 1 | Transfer in progress |
| sub_busy | output | NUM_SUB | Local sense amplifiers of a subarray occupied |
| done | output | 1 | Transfer complete pulse |
| done_slots | output | NUM_SUB | Slot now holding the data, per destination |
| err | output | 1 | Request rejected pulse |

## Verification
The bench aims at the slot ping-pong across consecutive copies that share a subarray. If the pointer did not flip, or flipped for the wrong subarray, the bus read would name the slot that was not just filled, or two destinations would report the same slot twice in a row. It sends requests that the holding register has to park while a transfer is running. A design that dropped or overwrote such a request would produce a command stream missing a whole job. Rejected masks (five destinations, the source's own bit, empty) are checked to leave the command stream silent. The timing gaps between commands are checked every cycle, so an off-by-one in any wait count shows up as a shifted strobe.

// File: rtl/xcopy_pkg.sv
package xcopy_pkg;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_ACT_ROW = 3'd1,
    OP_ACT_SHR = 3'd2,
    OP_PRE_SUB = 3'd3,
    OP_GWL_SRC = 3'd4,
    OP_GWL_DST = 3'd5,
    OP_PRE_BUS = 3'd6
  } cmd_op_e;

  // number of set bits in a mask (masks are zero-extended to 64 bits)
  function automatic int unsigned bit_count(input logic [63:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 64; i++) n += int'(v[i]);
    return n;
  endfunction

  // a destination set is legal when non-empty, small enough, and excludes the source
  function automatic logic mask_legal(input logic [63:0] mask, input int unsigned src,
                                      input int unsigned max_dst);
    return (mask != 64'd0) && !mask[src[5:0]] && (bit_count(mask) <= max_dst);
  endfunction

  function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/xcopy_hold.sv
module xcopy_hold #(
  parameter int NUM_SUB = 8,
  parameter int ROW_W   = 9,
  localparam int SUB_W  = $clog2(NUM_SUB)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [SUB_W-1:0]   in_src,
  input  logic [ROW_W-1:0]   in_row,
  input  logic [NUM_SUB-1:0] in_mask,
  input  logic               in_staged,
  input  logic               pop,
  output logic               out_valid,
  output logic [SUB_W-1:0]   out_src,
  output logic [ROW_W-1:0]   out_row,
  output logic [NUM_SUB-1:0] out_mask,
  output logic               out_staged
);

  logic accept;
  assign in_ready = !out_valid;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_src    <= '0;
      out_row    <= '0;
      out_mask   <= '0;
      out_staged <= 1'b0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_src    <= in_src;
      out_row    <= in_row;
      out_mask   <= in_mask;
      out_staged <= in_staged;
    end else if (pop) begin
      out_valid  <= 1'b0;
    end
  end

  // R8
  held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !pop |=> out_valid && $stable(out_src) && $stable(out_mask) && $stable(out_row));

endmodule

// File: rtl/xcopy_slots.sv
module xcopy_slots #(
  parameter int NUM_SUB = 8,
  localparam int SUB_W  = $clog2(NUM_SUB)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clone_we,
  input  logic [SUB_W-1:0]   clone_sub,
  input  logic               bus_we,
  input  logic [NUM_SUB-1:0] bus_mask,
  output logic [NUM_SUB-1:0] wr_slot
);

  for (genvar i = 0; i < NUM_SUB; i++) begin : g_ptr
    logic flip;
    assign flip = (clone_we && (clone_sub == SUB_W'(i))) || (bus_we && bus_mask[i]);
    always_ff @(posedge clk) begin
      if (!rst_n)    wr_slot[i] <= 1'b0;
      else if (flip) wr_slot[i] <= ~wr_slot[i];
    end
  end

  // R6
  single_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(clone_we && bus_we));

endmodule

// File: rtl/xcopy_engine.sv
module xcopy_engine import xcopy_pkg::*; #(
  parameter int NUM_SUB = 8,
  parameter int ROW_W   = 9,
  parameter int MAX_DST = 4,
  parameter int T_RCD   = 11,
  parameter int T_RAS   = 28,
  parameter int T_RP    = 11,
  parameter int T_GAP   = 4,
  localparam int SUB_W  = $clog2(NUM_SUB),
  localparam int T_MAX  = int'(max_of4(T_RCD, T_RAS, T_RP, T_GAP)),
  localparam int CNT_W  = $clog2(T_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               job_valid,
  input  logic [SUB_W-1:0]   job_src,
  input  logic [ROW_W-1:0]   job_row,
  input  logic [NUM_SUB-1:0] job_mask,
  input  logic               job_staged,
  output logic               pop,
  output logic               err,
  input  logic [NUM_SUB-1:0] wr_slot,
  output logic               clone_we,
  output logic [SUB_W-1:0]   clone_sub,
  output logic               bus_we,
  output logic [NUM_SUB-1:0] bus_mask,
  output logic               cmd_valid,
  output logic [2:0]         cmd_op,
  output logic [SUB_W-1:0]   cmd_sub,
  output logic [ROW_W-1:0]   cmd_row,
  output logic [NUM_SUB-1:0] cmd_mask,
  output logic [NUM_SUB-1:0] cmd_slots,
  output logic               busy,
  output logic [NUM_SUB-1:0] sub_busy,
  output logic               done,
  output logic [NUM_SUB-1:0] done_slots
);

  typedef enum logic [2:0] {
    S_IDLE, S_ACT, S_ACTSH, S_PRE, S_GSRC, S_GDST, S_BPRE, S_FIN
  } st_e;

  localparam logic [CNT_W-1:0] W_RCD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] W_RAS = CNT_W'(T_RAS - 1);
  localparam logic [CNT_W-1:0] W_RP  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] W_GAP = CNT_W'(T_GAP - 1);

  st_e                state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [SUB_W-1:0]   src_q;
  logic [ROW_W-1:0]   row_q;
  logic [NUM_SUB-1:0] mask_q;
  logic               clone_q;
  logic [NUM_SUB-1:0] done_slots_q;

  logic job_ok, start, fire, src_slot;
  cmd_op_e op_now;

  assign job_ok   = mask_legal(64'(job_mask), int'(job_src), MAX_DST);
  assign pop      = (state_q == S_IDLE) && job_valid;
  assign err      = pop && !job_ok;
  assign start    = pop && job_ok;
  assign fire     = (state_q != S_IDLE) && (cnt_q == '0);
  assign src_slot = wr_slot[src_q];

  // next state and wait count
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (state_q == S_IDLE) begin
      if (start) begin
        state_d = job_staged ? S_GSRC : S_ACT;
        cnt_d   = '0;
      end
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      unique case (state_q)
        S_ACT:   begin state_d = S_ACTSH; cnt_d = W_RCD; end
        S_ACTSH: begin state_d = S_PRE;   cnt_d = W_RAS; end
        S_PRE:   begin state_d = S_GSRC;  cnt_d = W_RP;  end
        S_GSRC:  begin state_d = S_GDST;  cnt_d = W_GAP; end
        S_GDST:  begin state_d = S_BPRE;  cnt_d = W_RAS; end
        S_BPRE:  begin state_d = S_FIN;   cnt_d = W_RP;  end
        default: begin state_d = S_IDLE;  cnt_d = '0;    end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      cnt_q        <= '0;
      src_q        <= '0;
      row_q        <= '0;
      mask_q       <= '0;
      clone_q      <= 1'b0;
      done_slots_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (start) begin
        src_q   <= job_src;
        row_q   <= job_row;
        mask_q  <= job_mask;
        clone_q <= !job_staged;
      end else if (fire && state_q == S_GSRC) begin
        clone_q <= 1'b0;
      end
      if (bus_we) done_slots_q <= wr_slot & mask_q;
    end
  end

  // command decode
  always_comb begin
    op_now    = OP_NONE;
    cmd_row   = '0;
    cmd_mask  = '0;
    cmd_slots = '0;
    unique case (state_q)
      S_ACT:   begin op_now = OP_ACT_ROW; cmd_row = row_q; end
      S_ACTSH: begin op_now = OP_ACT_SHR; cmd_row = {{(ROW_W-1){1'b0}}, src_slot}; end
      S_PRE:   op_now = OP_PRE_SUB;
      S_GSRC:  begin op_now = OP_GWL_SRC; cmd_row = {{(ROW_W-1){1'b0}}, ~src_slot}; end
      S_GDST:  begin op_now = OP_GWL_DST; cmd_mask = mask_q; cmd_slots = wr_slot & mask_q; end
      S_BPRE:  op_now = OP_PRE_BUS;
      default: op_now = OP_NONE;
    endcase
    if (!fire) begin
      op_now    = OP_NONE;
      cmd_row   = '0;
      cmd_mask  = '0;
      cmd_slots = '0;
    end
  end

  assign cmd_valid  = op_now != OP_NONE;
  assign cmd_op     = op_now;
  assign cmd_sub    = cmd_valid ? src_q : '0;
  assign clone_we   = fire && (state_q == S_ACTSH);
  assign clone_sub  = src_q;
  assign bus_we     = fire && (state_q == S_GDST);
  assign bus_mask   = mask_q;
  assign busy       = state_q != S_IDLE;
  assign done       = fire && (state_q == S_FIN);
  assign done_slots = done ? done_slots_q : '0;
  assign sub_busy   = (clone_q && !(fire && state_q == S_GSRC)) ?
                      (NUM_SUB'(1) << src_q) : '0;

  // R4
  dst_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_GWL_DST |->
      $countones(cmd_mask) <= MAX_DST && cmd_mask != '0 && !cmd_mask[cmd_sub]);

  // R7
  bus_leaves_sa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op inside {OP_GWL_SRC, OP_GWL_DST, OP_PRE_BUS}) |-> sub_busy == '0);

  // R7
  one_busy_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sub_busy));

  // R5
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !cmd_valid && !busy);

  // R9
  done_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_slots & ~mask_q) == '0 && !cmd_valid);

endmodule

// File: rtl/xsub_copy_seq.sv
module xsub_copy_seq #(
  parameter int NUM_SUB = 8,
  parameter int ROW_W   = 9,
  parameter int MAX_DST = 4,
  parameter int T_RCD   = 11,
  parameter int T_RAS   = 28,
  parameter int T_RP    = 11,
  parameter int T_GAP   = 4,
  localparam int SUB_W  = $clog2(NUM_SUB)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [SUB_W-1:0]   req_src,
  input  logic [ROW_W-1:0]   req_row,
  input  logic [NUM_SUB-1:0] req_mask,
  input  logic               req_staged,
  output logic               cmd_valid,
  output logic [2:0]         cmd_op,
  output logic [SUB_W-1:0]   cmd_sub,
  output logic [ROW_W-1:0]   cmd_row,
  output logic [NUM_SUB-1:0] cmd_mask,
  output logic [NUM_SUB-1:0] cmd_slots,
  output logic               busy,
  output logic [NUM_SUB-1:0] sub_busy,
  output logic               done,
  output logic [NUM_SUB-1:0] done_slots,
  output logic               err
);

  logic               h_valid, h_staged, pop;
  logic [SUB_W-1:0]   h_src;
  logic [ROW_W-1:0]   h_row;
  logic [NUM_SUB-1:0] h_mask;
  logic               clone_we, bus_we;
  logic [SUB_W-1:0]   clone_sub;
  logic [NUM_SUB-1:0] bus_mask, wr_slot;

  xcopy_hold #(.NUM_SUB(NUM_SUB), .ROW_W(ROW_W)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready),
    .in_src(req_src), .in_row(req_row), .in_mask(req_mask), .in_staged(req_staged),
    .pop(pop),
    .out_valid(h_valid), .out_src(h_src), .out_row(h_row),
    .out_mask(h_mask), .out_staged(h_staged)
  );

  xcopy_slots #(.NUM_SUB(NUM_SUB)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .clone_we(clone_we), .clone_sub(clone_sub),
    .bus_we(bus_we), .bus_mask(bus_mask),
    .wr_slot(wr_slot)
  );

  xcopy_engine #(
    .NUM_SUB(NUM_SUB), .ROW_W(ROW_W), .MAX_DST(MAX_DST),
    .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_GAP(T_GAP)
  ) u_eng (
    .clk(clk), .rst_n(rst_n),
    .job_valid(h_valid), .job_src(h_src), .job_row(h_row),
    .job_mask(h_mask), .job_staged(h_staged),
    .pop(pop), .err(err),
    .wr_slot(wr_slot),
    .clone_we(clone_we), .clone_sub(clone_sub),
    .bus_we(bus_we), .bus_mask(bus_mask),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_sub(cmd_sub), .cmd_row(cmd_row),
    .cmd_mask(cmd_mask), .cmd_slots(cmd_slots),
    .busy(busy), .sub_busy(sub_busy),
    .done(done), .done_slots(done_slots)
  );

endmodule

// File: tb/sim_xsub_copy_seq.sv
module sim_xsub_copy_seq;

  localparam int NS = 8, RW = 9, SW = 3, MAXD = 4;
  localparam int RCD = 11, RAS = 28, RP = 11, GAP = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_staged;
  logic [SW-1:0] req_src, cmd_sub;
  logic [RW-1:0] req_row, cmd_row;
  logic [NS-1:0] req_mask, cmd_mask, cmd_slots, sub_busy, done_slots;
  logic cmd_valid, busy, done, err;
  logic [2:0] cmd_op;

  xsub_copy_seq #(.NUM_SUB(NS), .ROW_W(RW), .MAX_DST(MAXD),
                  .T_RCD(RCD), .T_RAS(RAS), .T_RP(RP), .T_GAP(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_row(req_row), .req_mask(req_mask), .req_staged(req_staged),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_sub(cmd_sub), .cmd_row(cmd_row),
    .cmd_mask(cmd_mask), .cmd_slots(cmd_slots), .busy(busy), .sub_busy(sub_busy),
    .done(done), .done_slots(done_slots), .err(err));

  int n_checks = 0, n_errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s at %0t: got %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int k = 0;
  bit m_hold_v = 0;
  int m_src, m_row;
  logic [NS-1:0] m_mask;
  bit m_staged;
  int job_start = -1, job_done = -1, job_busy_end = -1, job_src = 0;
  bit m_ws[NS];
  logic [NS-1:0] m_done_slots;
  int e_op[int], e_sub[int], e_row[int];
  logic [NS-1:0] e_mask[int], e_slots[int];
  int act_seen = 0, err_seen = 0, done_seen = 0;

  function automatic bit req_bad(input int src, input logic [NS-1:0] mask);
    int n = 0;
    foreach (mask[i]) if (mask[i]) n++;
    return (n == 0) || (n > MAXD) || mask[src];
  endfunction

  task automatic put(input int t, input int op, input int row,
                     input logic [NS-1:0] mk, input logic [NS-1:0] sl);
    e_op[t] = op; e_sub[t] = m_src; e_row[t] = row; e_mask[t] = mk; e_slots[t] = sl;
  endtask

  task automatic plan_job(input int q);
    int t;
    logic [NS-1:0] sv;
    t = q + 1;
    job_start = t;
    job_src = m_src;
    job_busy_end = -1;
    if (!m_staged) begin
      put(t, 1, m_row, '0, '0);  t += RCD;
      put(t, 2, int'(m_ws[m_src]), '0, '0);
      m_ws[m_src] = !m_ws[m_src]; t += RAS;
      put(t, 3, 0, '0, '0);      t += RP;
      job_busy_end = t - 1;
    end
    put(t, 4, int'(!m_ws[m_src]), '0, '0); t += GAP;
    sv = '0;
    for (int d = 0; d < NS; d++)
      if (m_mask[d]) begin sv[d] = m_ws[d]; m_ws[d] = !m_ws[d]; end
    put(t, 5, 0, m_mask, sv); t += RAS;
    put(t, 6, 0, '0, '0);      t += RP;
    job_done = t;
    m_done_slots = sv;
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit idle, ready_now;
      string tg;
      idle = (job_done < 0) || (k > job_done);
      ready_now = !m_hold_v;
      check(req_ready == ready_now, "R8 req_ready", int'(req_ready), int'(ready_now));
      check(busy == !idle, "R9 busy", int'(busy), int'(!idle));
      check(err == (idle && m_hold_v && req_bad(m_src, m_mask)), "R5 err",
            int'(err), int'(idle && m_hold_v && req_bad(m_src, m_mask)));
      if (e_op.exists(k)) begin
        tg = (e_op[k] <= 3) ? "R1 cmd" : (e_op[k] == 6 ? "R9 bus precharge" : "R2 cmd");
        check(cmd_valid === 1'b1, tg, int'(cmd_valid), 1);
        check(int'(cmd_op) == e_op[k], tg, int'(cmd_op), e_op[k]);
        check(int'(cmd_sub) == e_sub[k], tg, int'(cmd_sub), e_sub[k]);
        check(int'(cmd_row) == e_row[k], "R6 row/slot", int'(cmd_row), e_row[k]);
        check(cmd_mask == e_mask[k], "R4 mask", int'(cmd_mask), int'(e_mask[k]));
        check(cmd_slots == e_slots[k], "R6 slots", int'(cmd_slots), int'(e_slots[k]));
      end else begin
        check(cmd_valid === 1'b0, "R2 no cmd", int'(cmd_valid), 0);
      end
      check(done == (k == job_done), "R9 done", int'(done), int'(k == job_done));
      if (k == job_done)
        check(done_slots == m_done_slots, "R6 done_slots", int'(done_slots), int'(m_done_slots));
      begin
        logic [NS-1:0] eb;
        eb = (job_busy_end >= 0 && k >= job_start && k <= job_busy_end) ? NS'(1) << job_src : '0;
        check(sub_busy == eb, "R7 sub_busy", int'(sub_busy), int'(eb));
      end
      if (cmd_valid && cmd_op == 3'd1) act_seen++;
      if (err) err_seen++;
      if (done) done_seen++;
      // state update for next cycle
      if (idle && m_hold_v) begin
        if (!req_bad(m_src, m_mask)) plan_job(k);
        m_hold_v = 0;
      end
      if (req_valid && ready_now) begin
        m_hold_v = 1; m_src = int'(req_src); m_row = int'(req_row);
        m_mask = req_mask; m_staged = req_staged;
      end
      k++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input int src, input int row, input logic [NS-1:0] mask, input bit stg);
    @(posedge clk); #1;
    while (!req_ready) begin @(posedge clk); #1; end
    req_valid = 1; req_src = SW'(src); req_row = RW'(row); req_mask = mask; req_staged = stg;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic wait_idle();
    repeat (3) @(posedge clk);
    while (busy || !req_ready) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL R8 watchdog: got %0d expected %0d", 0, 1);
      summary();
    end
  end

  initial begin
    int a0, e0, d0;
    for (int i = 0; i < NS; i++) m_ws[i] = 0;
    rst_n = 0; req_valid = 0; req_src = '0; req_row = '0; req_mask = '0; req_staged = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check(req_ready === 1'b1, "R10 ready", int'(req_ready), 1);
    check(busy === 1'b0 && cmd_valid === 1'b0, "R10 idle", int'(busy | cmd_valid), 0);
    check(done === 1'b0 && err === 1'b0 && sub_busy == '0, "R10 flags", int'(done | err), 0);
    @(posedge clk); #1 rst_n = 1;

    // R1 R2: cloned single copy 2 -> 4
    send(2, 37, 8'b0001_0000, 0); wait_idle();
    // R3: staged copy 4 -> 2, no ACT_ROW
    a0 = act_seen;
    send(4, 0, 8'b0000_0100, 1); wait_idle();
    check(act_seen == a0, "R3 no clone", act_seen, a0);
    // R4 broadcast to four
    send(1, 5, 8'b1011_0001, 0); wait_idle();
    // R4 five destinations rejected
    a0 = act_seen; e0 = err_seen; d0 = done_seen;
    send(0, 3, 8'b0011_1110, 0); wait_idle();
    check(err_seen == e0 + 1, "R4 reject five", err_seen, e0 + 1);
    check(act_seen == a0 && done_seen == d0, "R4 silent", act_seen, a0);
    // R5 mask includes source, and empty mask
    e0 = err_seen; d0 = done_seen;
    send(3, 1, 8'b0000_1000, 0); wait_idle();
    send(3, 1, 8'b0000_0000, 1); wait_idle();
    check(err_seen == e0 + 2, "R5 reject", err_seen, e0 + 2);
    check(done_seen == d0, "R5 no done", done_seen, d0);
    // R8 back-to-back requests parked in the holding register
    d0 = done_seen;
    send(5, 100, 8'b0000_0001, 0);
    send(6, 200, 8'b0000_0010, 1);
    send(7, 511, 8'b0100_0000, 0);
    wait_idle();
    check(done_seen == d0 + 3, "R8 all jobs", done_seen, d0 + 3);
    // R6 repeated clone from the same subarray into the same destination
    send(2, 38, 8'b0001_0000, 0); wait_idle();
    send(2, 39, 8'b0001_0001, 0); wait_idle();
    check(done_seen == d0 + 5, "R9 done count", done_seen, d0 + 5);
    summary();
  end

endmodule